// File: doc/BRIEF.md
# PCM Converter Port Controller

This block sits between a byte-wide host port and an 8-bit sample converter path. It holds a control register for the converter's analog switches and buffering mode, a status byte that carries the external comparator result, a converter data port, and a 2-bit sample-period counter that advances at the base sample rate. The host selects one of two port addresses with a single select bit: select 1 reaches control (write) and status (read), and select 0 reaches converter data (write) and the counter (read).

The buffering mode sets how the data port behaves. In direct mode, which is used for recording by successive approximation, a written byte reaches the converter output on the clock edge that takes the write. In buffered mode, which is used for playback, a written byte is parked in a holding register and copied to the converter output on each counter tick. A data write in buffered mode also restarts the sample period. The mode itself is a two-state machine with states ST_DIRECT and ST_BUFFERED. A control write with bit 0 set takes the GO_BUFFERED transition, and a control write with bit 0 clear takes GO_DIRECT. Any other cycle holds the current state.

The tick comes from a prescaler of TICK_DIV clocks. The default of 682 turns a 10.738635 MHz clock into a period of about 63.5 µs.

Top module: `pcm_port_ctrl`

## Requirements
- R1: After reset the converter output is 0x00, all five control outputs are 0 (direct mode, sound off, ground level, low-pass source, sampling), the counter reads 0x00 and the status byte reads 0x00 while the comparator input is 0.
- R2: A control write (select 1) stores bits 4..0: bit 0 buffering mode, bit 1 mute, bit 2 filter select, bit 3 microphone select, bit 4 hold. Bits 7..5 of the written byte have no effect. The status read shows bits 4..1 at the same positions and the mode at bit 0.
- R3: Status bit 7 follows the comparator input in the same cycle, and status bits 6..5 always read 0.
- R4: A read with select 0 returns the counter in bits 1..0 and zeros in bits 7..2.
- R5: The counter advances by one every TICK_DIV clocks and wraps from 3 to 0.
- R6: In direct mode, a data write (select 0) appears on the converter output right after the clock edge that takes it.
- R7: In direct mode, a data write leaves the counter and the prescaler running.
- R8: In buffered mode, the converter output changes only on a tick, and it then takes the held byte.
- R9: In buffered mode, a data write clears the counter and the prescaler, so the next tick comes TICK_DIV clocks after the write.
- R10: A buffered-mode data write on the same edge as a tick sends the previously held byte to the output, holds the new byte and leaves the counter at 0.
- R11: In buffered mode, with no new write, each tick repeats the same held byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | Write strobe for one cycle |
| wr_sel | input | 1 | Write target: 1 control, 0 converter data |
| wr_data | input | 8 | Write byte |
| rd_sel | input | 1 | Read source: 1 status, 0 counter |
| rd_data | output | 8 | Read byte (combinational) |
| cmp_in | input | 1 | Comparator result: 1 when the converter output is below the held input |
| dac_out | output | 8 | Converter output byte |
| dbl_buf | output | 1 | Buffering mode (1 buffered) |
| mute_on | output | 1 | Sound output enable |
| filt_on | output | 1 | Filter output selected for the sample input (0 ground) |
| mic_sel | output | 1 | Microphone amplifier drives the low-pass input (0 converter) |
| hold_on | output | 1 | Sample-and-hold in hold (0 sampling) |

## Verification
The bench builds the block with TICK_DIV = 6 and the default 2-bit counter. Every tick edge, the wrap from 3 to 0, and the collision of a write with a tick then fall within a few dozen clocks of a known clearing write. The short period also lets the bench place a direct-mode write between two ticks and tell a cleared prescaler from a free-running one by a single cycle of difference in the next tick.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic {
        ST_DIRECT   = 1'b0,
        ST_BUFFERED = 1'b1
    } buf_mode_e;

    typedef struct packed {
        logic hold;
        logic mic;
        logic filt;
        logic mute;
    } ana_ctrl_t;

endpackage

// File: rtl/pcm_tick_gen.sv
module pcm_tick_gen #(
    parameter int TICK_DIV = 682,
    parameter int CNT_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic             tick,
    output logic [CNT_W-1:0] cnt
);
    localparam int PRE_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

    logic [PRE_W-1:0] pre_q;

    assign tick = (pre_q == PRE_LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            cnt   <= '0;
        end else if (clr) begin
            pre_q <= '0;
            cnt   <= '0;
        end else if (tick) begin
            pre_q <= '0;
            cnt   <= cnt + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/pcm_mode_fsm.sv
module pcm_mode_fsm
    import pcm_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic [4:0] ctrl_bits,
    output buf_mode_e  mode,
    output ana_ctrl_t  ana
);
    buf_mode_e state_q, state_d;
    ana_ctrl_t ana_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_DIRECT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DIRECT:   if (ctrl_wr && ctrl_bits[0])  state_d = ST_BUFFERED; // GO_BUFFERED
            ST_BUFFERED: if (ctrl_wr && !ctrl_bits[0]) state_d = ST_DIRECT;   // GO_DIRECT
            default:     state_d = ST_DIRECT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       ana_q <= '0;
        else if (ctrl_wr) ana_q <= ctrl_bits[4:1];
    end

    always_comb begin
        mode = state_q;
        ana  = ana_q;
    end
endmodule

// File: rtl/pcm_dac_path.sv
module pcm_dac_path
    import pcm_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] wr_data,
    input  buf_mode_e         mode,
    input  logic              tick,
    output logic [BYTE_W-1:0] dac_out
);
    logic [BYTE_W-1:0] held_q;

    always_ff @(posedge clk) begin
        if (!rst_n)       held_q <= '0;
        else if (data_wr) held_q <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_out <= '0;
        end else begin
            unique case (mode)
                ST_DIRECT:   if (data_wr) dac_out <= wr_data;
                ST_BUFFERED: if (tick)    dac_out <= held_q;
                default:     dac_out <= dac_out;
            endcase
        end
    end
endmodule

// File: rtl/pcm_port_ctrl.sv
module pcm_port_ctrl
    import pcm_port_pkg::*;
#(
    parameter int TICK_DIV = 682,
    parameter int CNT_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_sel,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              cmp_in,
    output logic [BYTE_W-1:0] dac_out,
    output logic              dbl_buf,
    output logic              mute_on,
    output logic              filt_on,
    output logic              mic_sel,
    output logic              hold_on
);
    logic             ctrl_wr, data_wr, cnt_clr, tick;
    logic [CNT_W-1:0] cnt;
    buf_mode_e        mode;
    ana_ctrl_t        ana;

    assign ctrl_wr = wr_stb && wr_sel;
    assign data_wr = wr_stb && !wr_sel;
    assign cnt_clr = data_wr && (mode == ST_BUFFERED);

    pcm_tick_gen #(.TICK_DIV(TICK_DIV), .CNT_W(CNT_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .tick(tick), .cnt(cnt)
    );

    pcm_mode_fsm u_mode (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr),
        .ctrl_bits(wr_data[4:0]), .mode(mode), .ana(ana)
    );

    pcm_dac_path u_dac (
        .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .wr_data(wr_data),
        .mode(mode), .tick(tick), .dac_out(dac_out)
    );

    assign dbl_buf = (mode == ST_BUFFERED);
    assign mute_on = ana.mute;
    assign filt_on = ana.filt;
    assign mic_sel = ana.mic;
    assign hold_on = ana.hold;

    always_comb begin
        if (rd_sel) rd_data = {cmp_in, 2'b00, ana.hold, ana.mic, ana.filt, ana.mute, dbl_buf};
        else        rd_data = BYTE_W'(cnt);
    end
endmodule

// File: rtl/pcm_port_ctrl_chk.sv
module pcm_port_ctrl_chk #(
    parameter int CNT_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_stb,
    input logic             wr_sel,
    input logic [7:0]       wr_data,
    input logic             rd_sel,
    input logic [7:0]       rd_data,
    input logic             cmp_in,
    input logic [7:0]       dac_out,
    input logic             dbl_buf,
    input logic             tick,
    input logic [CNT_W-1:0] cnt
);
    // R2
    mode_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_sel) |=> (dbl_buf == $past(wr_data[0])));

    // R3
    status_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sel |-> (rd_data[7] == cmp_in && rd_data[6:5] == 2'b00));

    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !(wr_stb && !wr_sel && dbl_buf)) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

    // R6
    direct_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !wr_sel && !dbl_buf) |=> (dac_out == $past(wr_data)));

    // R7
    direct_keep_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !wr_sel && !dbl_buf && !tick) |=> (cnt == $past(cnt)));

    // R8
    buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbl_buf && !tick) |=> $stable(dac_out));

    // R9
    buf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !wr_sel && dbl_buf) |=> (cnt == '0));
endmodule

bind pcm_port_ctrl pcm_port_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .cmp_in(cmp_in),
    .dac_out(dac_out), .dbl_buf(dbl_buf), .tick(tick), .cnt(cnt)
);

// File: tb/tb_pcm_port_ctrl.sv
module tb_pcm_port_ctrl;
    localparam int DIV = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_stb = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0, cmp_in = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data, dac_out;
    logic       dbl_buf, mute_on, filt_on, mic_sel, hold_on;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 0;

    typedef struct {
        int         kind;   // 0 dac_out, 1 rd_data, 2 control outputs
        logic [7:0] exp;
        string      req;
    } item_t;
    item_t q[$];
    item_t it;

    always #2.5 clk = ~clk;

    pcm_port_ctrl #(.TICK_DIV(DIV), .CNT_W(2)) dut (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .cmp_in(cmp_in),
        .dac_out(dac_out), .dbl_buf(dbl_buf), .mute_on(mute_on),
        .filt_on(filt_on), .mic_sel(mic_sel), .hold_on(hold_on)
    );

    // monitor: compare queued expectations away from the active edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            logic [7:0] act;
            it = q.pop_front();
            case (it.kind)
                0:       act = dac_out;
                1:       act = rd_data;
                default: act = {3'b000, hold_on, mic_sel, filt_on, mute_on, dbl_buf};
            endcase
            n_checks++;
            if (act !== it.exp) begin
                n_err++;
                $display("FAIL %s: actual=%02h expected=%02h", it.req, act, it.exp);
            end
        end
    end

    task automatic exp_item(input int kind, input logic [7:0] v, input string req);
        item_t e;
        e.kind = kind; e.exp = v; e.req = req;
        q.push_back(e);
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        wr_stb = 1'b1; wr_sel = sel; wr_data = d;
        @(posedge clk); #1;
        wr_stb = 1'b0;
    endtask

    task automatic read_chk(input logic sel, input logic [7:0] v, input string req);
        rd_sel = sel; #0.5;
        exp_item(1, v, req);
        cyc(1);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        // R1 reset state
        exp_item(0, 8'h00, "R1 dac");
        exp_item(2, 8'h00, "R1 ctrl");
        read_chk(1'b0, 8'h00, "R1 R4 counter");
        read_chk(1'b1, 8'h00, "R1 status");
        cmp_in = 1'b1;
        read_chk(1'b1, 8'h80, "R3 comparator bit");

        // R2 control write, upper bits ignored
        wr(1'b1, 8'hFF);
        exp_item(2, 8'h1F, "R2 ctrl all");
        read_chk(1'b1, 8'h9F, "R2 R3 status mirror");
        cmp_in = 1'b0;
        wr(1'b1, 8'h0A);
        exp_item(2, 8'h0A, "R2 ctrl mute mic");
        read_chk(1'b1, 8'h0A, "R2 status mirror");
        rd_sel = 1'b0;

        // R6 direct mode
        wr(1'b0, 8'h5A);
        exp_item(0, 8'h5A, "R6 direct first");
        wr(1'b0, 8'hC3);
        exp_item(0, 8'hC3, "R6 direct second");

        // R8 R9 buffered mode
        wr(1'b1, 8'h01);
        exp_item(2, 8'h01, "R2 buffered mode");
        wr(1'b0, 8'h77);
        exp_item(0, 8'hC3, "R8 held not shown");
        exp_item(1, 8'h00, "R9 counter cleared");
        cyc(DIV - 1);
        exp_item(0, 8'hC3, "R8 before tick");
        exp_item(1, 8'h00, "R9 before tick");
        cyc(1);
        exp_item(0, 8'h77, "R8 on tick");
        exp_item(1, 8'h01, "R9 R4 first tick");
        cyc(DIV);
        exp_item(1, 8'h02, "R5 second tick");
        exp_item(0, 8'h77, "R11 repeat");
        cyc(2 * DIV);
        exp_item(1, 8'h00, "R5 wrap");
        exp_item(0, 8'h77, "R11 repeat after wrap");

        // R10 write on tick edge
        wr(1'b0, 8'h99);
        exp_item(0, 8'h77, "R10 pre");
        cyc(DIV - 1);
        wr(1'b0, 8'h3C);
        exp_item(0, 8'h99, "R10 old byte sent");
        exp_item(1, 8'h00, "R10 counter cleared");
        cyc(DIV - 1);
        exp_item(0, 8'h99, "R10 new byte held");
        cyc(1);
        exp_item(0, 8'h3C, "R10 new byte sent");
        exp_item(1, 8'h01, "R10 counter tick");

        // R7 direct write keeps counter
        wr(1'b0, 8'h11);
        wr(1'b1, 8'h00);
        exp_item(2, 8'h00, "R2 back to direct");
        wr(1'b0, 8'hE4);
        exp_item(0, 8'hE4, "R6 direct after switch");
        cyc(DIV - 3);
        exp_item(1, 8'h00, "R7 before tick");
        cyc(1);
        exp_item(1, 8'h01, "R7 tick not delayed");
        cyc(2);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            n_err++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end
endmodule